// File: doc/BRIEF.md
# Prioritized Multi-Source Interrupt Controller

This block gathers up to 64 external interrupt request lines and turns them into a single request to a processor. Each line has its own 2-bit trigger mode: active-low level, active-high level, falling edge or rising edge. Each line also has its own 3-bit priority. A priority of zero masks the line. A global threshold and a global enable decide which pending lines may reach the processor. Among the eligible lines, one winner is reported through a status word.

Software reaches the block through a simple word-addressed bus. A write takes effect on the clock edge where `bus_wr` is high, and a read is combinational from `bus_addr`. Edge-triggered lines hold their event in a latch. Software clears that latch by writing an encoded source index, usually after it has serviced the event. Line 0 is a placeholder and never produces a request.

Top module: `intc_top`

## Requirements
- R1: After reset, the enable, the threshold, every priority and every trigger mode read as zero. `irq_out` is low and the status word reads 0x0001_0000.
- R2: While bit 0 of the control word (address 0) is clear, `irq_out` stays low and the status word reports nothing pending, whatever the lines do.
- R3: Line 0 is never reported and never raises `irq_out`, whatever its priority, mode or input.
- R4: Trigger mode 00 makes a line pending while its input is low. Mode 01 makes it pending while its input is high. The pending state follows the input after two synchronizer cycles.
- R5: Mode 10 latches a high-to-low transition and mode 11 latches a low-to-high transition. The latch stays set after the input returns, until it is cleared.
- R6: A write to address 3 clears edge latches of lines 0–31, and a write to address 4 clears those of lines 32–63. Bit 8 enables clearing line base+bits[3:0]. Bit 24 enables clearing line base+16+bits[19:16]. A write without its enable bit clears nothing.
- R7: Priorities sit in bits 2:0 of 8-bit lanes. Line s uses address 16+s/4, lane s%4. A priority of 0 keeps a line from being delivered.
- R8: A line is delivered only when its priority is strictly greater than the threshold held in bits 2:0 of address 1.
- R9: Among the eligible lines, the one with the highest priority wins. A tie goes to the lowest line number.
- R10: The status word (address 2) holds the winning line number in bits 5:0 and zeros elsewhere. When no line is eligible it reads 0x0001_0000, with bit 16 as the none-pending flag.
- R11: `irq_out` is high exactly when the status word reports a winner.
- R12: Modes are 2 bits per line. Line s uses address 8+s/16, bits 2*(s%16)+1:2*(s%16). Control, threshold, mode and priority words read back what was written, with unimplemented bits reading zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| src_in | input | 64 | Raw request lines, one per source |
| irq_out | output | 1 | Aggregated request to the processor |

## Verification
The hardest state to reach is a latched edge whose input has already returned to its idle level. In that state the status word must keep naming the line, even though nothing at the pins still points to it. A clear write that carries the wrong index, or lacks its enable bit, must then leave that state intact. The stimulus gets there by programming a line for an edge mode, toggling its input through the transition and back, and then sending a malformed clear and a correct one. It does this for both the lower and the upper 16-line half of a clear word. In parallel, other level lines are kept pending, so that each clear shows up as a change of winner rather than only as a flag.

// File: rtl/intc_pkg.sv
package intc_pkg;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_FALL = 2'b10,
    TRIG_RISE = 2'b11
  } trig_e;

  localparam int ADR_CTRL   = 0;
  localparam int ADR_THRESH = 1;
  localparam int ADR_STATUS = 2;
  localparam int ADR_ECLR   = 3;
  localparam int ADR_MODE   = 8;
  localparam int ADR_LEVEL  = 16;
  localparam int NONE_BIT   = 16;
  localparam int CLR_GROUP  = 32;
  localparam int CLR_HALF   = 16;

  function automatic logic trig_is_edge(input logic [1:0] m);
    return m[1];
  endfunction

  function automatic logic level_active(input logic [1:0] m, input logic v);
    return m[0] ? v : ~v;
  endfunction

  function automatic logic edge_seen(input logic [1:0] m, input logic now, input logic was);
    return m[1] && (m[0] ? (now && !was) : (!now && was));
  endfunction

  function automatic int mode_word(input int s, input int per_word);
    return ADR_MODE + s / per_word;
  endfunction

  function automatic int level_word(input int s, input int per_word);
    return ADR_LEVEL + s / per_word;
  endfunction

  function automatic int clr_word(input int s);
    return ADR_ECLR + s / CLR_GROUP;
  endfunction

  function automatic int clr_lane(input int s);
    return (s % CLR_GROUP) / CLR_HALF;
  endfunction

endpackage

// File: rtl/intc_cond.sv
module intc_cond
  import intc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       raw,
  input  logic [1:0] mode,
  input  logic       clr,
  output logic       pend
);
  logic sync1, sync2, prev, latch_q;
  logic hit;

  assign hit = edge_seen(mode, sync2, prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1   <= 1'b0;
      sync2   <= 1'b0;
      prev    <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      sync1 <= raw;
      sync2 <= sync1;
      prev  <= sync2;
      if (!trig_is_edge(mode)) latch_q <= 1'b0;
      else if (hit)            latch_q <= 1'b1;   // new event outranks a clear
      else if (clr)            latch_q <= 1'b0;
    end
  end

  assign pend = trig_is_edge(mode) ? latch_q : level_active(mode, sync2);
endmodule

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int NSRC = 64,
  parameter int PW   = 3,
  parameter int DW   = 32,
  parameter int AW   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  input  logic [DW-1:0]     status,
  output logic [DW-1:0]     rdata,
  output logic              en,
  output logic [PW-1:0]     thr,
  output logic [NSRC*PW-1:0] prio_flat,
  output logic [NSRC*2-1:0] mode_flat,
  output logic [NSRC-1:0]   clr_vec
);
  localparam int MPR = DW / 2;
  localparam int LPR = DW / 8;

  logic [1:0]    mode_q [NSRC];
  logic [PW-1:0] prio_q [NSRC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en  <= 1'b0;
      thr <= '0;
    end else if (wr) begin
      if (int'(addr) == ADR_CTRL)   en  <= wdata[0];
      if (int'(addr) == ADR_THRESH) thr <= wdata[PW-1:0];
    end
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    localparam int LN = clr_lane(s);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_q[s] <= TRIG_LOW;
        prio_q[s] <= '0;
      end else if (wr) begin
        if (int'(addr) == mode_word(s, MPR))  mode_q[s] <= wdata[2*(s%MPR) +: 2];
        if (int'(addr) == level_word(s, LPR)) prio_q[s] <= wdata[8*(s%LPR) +: PW];
      end
    end
    assign mode_flat[2*s +: 2]  = mode_q[s];
    assign prio_flat[s*PW +: PW] = prio_q[s];
    assign clr_vec[s] = wr && (int'(addr) == clr_word(s)) && wdata[8 + 16*LN]
                        && (wdata[16*LN +: 4] == 4'(s % CLR_HALF));
  end

  always_comb begin
    rdata = '0;
    if (int'(addr) == ADR_CTRL)   rdata[0] = en;
    if (int'(addr) == ADR_THRESH) rdata[PW-1:0] = thr;
    if (int'(addr) == ADR_STATUS) rdata = status;
    for (int s = 0; s < NSRC; s++) begin
      if (int'(addr) == mode_word(s, MPR))  rdata[2*(s%MPR) +: 2]  = mode_q[s];
      if (int'(addr) == level_word(s, LPR)) rdata[8*(s%LPR) +: PW] = prio_q[s];
    end
  end
endmodule

// File: rtl/intc_arb.sv
module intc_arb #(
  parameter int NSRC = 64,
  parameter int PW   = 3,
  localparam int IW  = $clog2(NSRC)
) (
  input  logic               en,
  input  logic [PW-1:0]      thr,
  input  logic [NSRC-1:0]    pend,
  input  logic [NSRC*PW-1:0] prio_flat,
  output logic [NSRC-1:0]    elig,
  output logic               found,
  output logic [IW-1:0]      win_idx,
  output logic [PW-1:0]      win_prio
);
  logic any;

  assign elig[0] = 1'b0;   // slot 0 is a placeholder
  for (genvar s = 1; s < NSRC; s++) begin : g_elig
    assign elig[s] = pend[s] && (prio_flat[s*PW +: PW] > thr);
  end

  always_comb begin
    any      = 1'b0;
    win_idx  = '0;
    win_prio = '0;
    for (int s = 1; s < NSRC; s++) begin
      if (elig[s] && (!any || prio_flat[s*PW +: PW] > win_prio)) begin
        any      = 1'b1;
        win_idx  = IW'(s);
        win_prio = prio_flat[s*PW +: PW];
      end
    end
  end

  assign found = en && any;
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [63:0] src_in,
  output logic        irq_out
);
  localparam int NSRC = 64;
  localparam int PW   = 3;
  localparam int DW   = 32;
  localparam int AW   = 6;
  localparam int IW   = $clog2(NSRC);

  logic               en;
  logic [PW-1:0]      thr;
  logic [NSRC*PW-1:0] prio_flat;
  logic [NSRC*2-1:0]  mode_flat;
  logic [NSRC-1:0]    clr_vec, pend, elig;
  logic               found;
  logic [IW-1:0]      win_idx;
  logic [PW-1:0]      win_prio;
  logic [DW-1:0]      status;

  intc_regs #(.NSRC(NSRC), .PW(PW), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .status(status), .rdata(bus_rdata), .en(en), .thr(thr),
    .prio_flat(prio_flat), .mode_flat(mode_flat), .clr_vec(clr_vec)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_cond
    intc_cond u_cond (
      .clk(clk), .rst_n(rst_n), .raw(src_in[s]),
      .mode(mode_flat[2*s +: 2]), .clr(clr_vec[s]), .pend(pend[s])
    );
  end

  intc_arb #(.NSRC(NSRC), .PW(PW)) u_arb (
    .en(en), .thr(thr), .pend(pend), .prio_flat(prio_flat),
    .elig(elig), .found(found), .win_idx(win_idx), .win_prio(win_prio)
  );

  always_comb begin
    status = '0;
    if (found) status[IW-1:0] = win_idx;
    else       status[NONE_BIT] = 1'b1;
  end

  assign irq_out = found;
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
  parameter int NSRC = 64,
  parameter int PW   = 3,
  parameter int DW   = 32,
  localparam int IW  = $clog2(NSRC)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               en,
  input logic [PW-1:0]      thr,
  input logic               found,
  input logic [IW-1:0]      win_idx,
  input logic [PW-1:0]      win_prio,
  input logic [NSRC-1:0]    elig,
  input logic [NSRC-1:0]    pend,
  input logic [NSRC-1:0]    clr_vec,
  input logic [NSRC*2-1:0]  mode_flat,
  input logic [DW-1:0]      status,
  input logic               irq
);
  logic [NSRC-1:0] emask;
  always_comb for (int s = 0; s < NSRC; s++) emask[s] = mode_flat[2*s+1];

  p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n) !en |-> !irq);
  p_slot0_never_r3: assert property (@(posedge clk) disable iff (!rst_n) irq |-> status[IW-1:0] != '0);
  p_edge_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pend & emask & ~clr_vec) & emask & ~pend) == '0);
  p_above_thr_r8: assert property (@(posedge clk) disable iff (!rst_n) found |-> win_prio > thr);
  p_winner_elig_r9: assert property (@(posedge clk) disable iff (!rst_n) found |-> elig[win_idx]);
  p_none_flag_r10: assert property (@(posedge clk) disable iff (!rst_n) status[16] == !irq);
  p_irq_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> status[IW-1:0] == win_idx);
endmodule

bind intc_top intc_chk #(.NSRC(64), .PW(3), .DW(32)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .thr(thr), .found(found), .win_idx(win_idx),
  .win_prio(win_prio), .elig(elig), .pend(pend), .clr_vec(clr_vec),
  .mode_flat(mode_flat), .status(status), .irq(irq_out)
);

// File: tb/sim_intc_top.sv
`timescale 1ns/100ps
module sim_intc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] src = '1;
  logic        irq_out;

  always #2.5 clk = ~clk;

  intc_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src), .irq_out(irq_out)
  );

  typedef struct {
    logic [31:0] exp;
    logic        chk_irq;
    logic        exp_irq;
    string       tag;
  } item_t;
  item_t q[$];

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [2:0] m_prio [64];
  logic [1:0] m_mode [64];
  logic       m_latch[64];
  logic       m_en = 0;
  logic [2:0] m_thr = 0;

  function automatic logic [31:0] m_status();
    int best = -1;
    int bp = 0;
    for (int s = 1; s < 64; s++) begin
      logic p;
      p = m_mode[s][1] ? m_latch[s] : (m_mode[s][0] ? src[s] : !src[s]);
      if (p && m_prio[s] > m_thr && (best < 0 || int'(m_prio[s]) > bp)) begin
        best = s; bp = int'(m_prio[s]);
      end
    end
    if (!m_en || best < 0) return 32'h0001_0000;
    return 32'(best);
  endfunction

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_cmp++;
      if (bus_rdata !== it.exp || (it.chk_irq && irq_out !== it.exp_irq)) begin
        n_bad++;
        $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                 it.tag, bus_rdata, irq_out, it.exp, it.exp_irq);
      end
    end
  end

  task automatic expect_rd(input int a, input logic [31:0] e, input logic ci,
                           input logic ei, input string tag);
    item_t it;
    @(posedge clk); #1;
    bus_addr = 6'(a);
    it.exp = e; it.chk_irq = ci; it.exp_irq = ei; it.tag = tag;
    q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic check_status(input string tag);
    logic [31:0] e;
    e = m_status();
    expect_rd(2, e, 1'b1, e != 32'h0001_0000, tag);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = 6'(a); bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic set_prio(input int s, input logic [2:0] p);
    logic [31:0] w;
    int r;
    m_prio[s] = p;
    r = s / 4;
    w = '0;
    for (int k = 0; k < 4; k++) w[8*k +: 8] = {5'b0, m_prio[4*r+k]};
    wr(16 + r, w);
  endtask

  task automatic set_mode(input int s, input logic [1:0] m);
    logic [31:0] w;
    int r;
    m_mode[s] = m;
    if (!m[1]) m_latch[s] = 1'b0;
    r = s / 16;
    w = '0;
    for (int k = 0; k < 16; k++) w[2*k +: 2] = m_mode[16*r+k];
    wr(8 + r, w);
  endtask

  task automatic set_in(input int s, input logic v);
    logic old;
    @(posedge clk); #1;
    old = src[s];
    src[s] = v;
    if ((m_mode[s] == 2'b11 && !old && v) || (m_mode[s] == 2'b10 && old && !v))
      m_latch[s] = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  task automatic clr(input int a, input logic [31:0] d);
    int base;
    base = (a - 3) * 32;
    if (d[8])  m_latch[base + int'(d[3:0])] = 1'b0;
    if (d[24]) m_latch[base + 16 + int'(d[19:16])] = 1'b0;
    wr(a, d);
    repeat (2) @(posedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 64; s++) begin m_prio[s] = 0; m_mode[s] = 0; m_latch[s] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset state
    expect_rd(2, 32'h0001_0000, 1'b1, 1'b0, "R1 status after reset");
    expect_rd(0, 32'h0, 1'b0, 1'b0, "R1 ctrl after reset");
    expect_rd(1, 32'h0, 1'b0, 1'b0, "R1 threshold after reset");
    expect_rd(16 + 5, 32'h0, 1'b0, 1'b0, "R1 level word after reset");
    expect_rd(10, 32'h0, 1'b0, 1'b0, "R1 mode word after reset");

    // R2 / R4: active-low line with controller disabled
    set_prio(5, 3);
    set_in(5, 0);
    check_status("R2 disabled hides pending line");
    wr(0, 1); m_en = 1;
    check_status("R4 low level pending, R10 status index");
    set_in(5, 1);
    check_status("R4 low level released");
    set_mode(5, 2'b01);
    check_status("R4 high level pending, R11 irq");
    set_in(5, 0);

    // R3: slot 0
    set_prio(0, 7);
    set_mode(0, 2'b01);
    check_status("R3 slot 0 never reported");

    // R8 / R7: threshold and zero priority
    set_mode(9, 2'b01);
    set_prio(9, 2);
    wr(1, 2); m_thr = 2;
    check_status("R8 equal to threshold blocked");
    wr(1, 1); m_thr = 1;
    check_status("R8 above threshold delivered");
    set_prio(9, 0);
    check_status("R7 zero priority masks");

    // R9: arbitration
    set_prio(9, 4);
    set_mode(40, 2'b01); set_prio(40, 6);
    set_mode(20, 2'b01); set_prio(20, 6);
    check_status("R9 tie goes to lower index");
    set_prio(20, 2);
    check_status("R9 highest priority wins");

    // R5 / R6: rising edge in the upper bank, lower half of clear word
    set_mode(33, 2'b11); set_prio(33, 7);
    set_in(33, 0);
    check_status("R5 falling transition ignored in rise mode");
    set_in(33, 1);
    check_status("R5 rising edge latched");
    set_in(33, 0);
    check_status("R5 latch holds after input returns");
    clr(4, 32'h0000_0102);
    check_status("R6 clear with wrong index ignored");
    clr(4, 32'h0000_0101);
    check_status("R6 clear releases latch");

    // R5 / R6: falling edge, upper half of clear word
    set_mode(50, 2'b10); set_prio(50, 7);
    set_in(50, 0);
    check_status("R5 falling edge latched");
    clr(4, 32'h0002_0000);
    check_status("R6 clear without enable ignored");
    clr(4, 32'h0102_0000);
    check_status("R6 upper-half clear releases latch");

    // R12: readback
    expect_rd(16 + 12, 32'h0007_0000, 1'b0, 1'b0, "R12 level word readback");
    expect_rd(11, 32'h0000_0020, 1'b0, 1'b0, "R12 mode word readback");
    expect_rd(1, 32'h1, 1'b0, 1'b0, "R12 threshold readback");
    expect_rd(0, 32'h1, 1'b0, 1'b0, "R12 ctrl readback");

    // R2: disable again
    wr(0, 0); m_en = 0;
    check_status("R2 disable drops irq");

    repeat (2) @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule